// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Byte-Wide Register Access

This block is a 16-bit up-counter that software reaches through an 8-bit register bus. Its count source is either an internal one-cycle tick strobe (one pulse per instruction cycle) or the rising edges of an external clock pin. The external pin is sampled by the system clock. It passes either through a two-flop synchronizer or through a single register stage, and then into a rising-edge detector. A power-of-two prescaler (divide by 1, 2, 4 or 8) sits between the selected source and the counter. A run-enable input gates the source. When the counter wraps from all ones to zero, it sets an overflow flag that stays set until software clears it.

Software sees the count as two byte addresses. The high byte is reached through a holding buffer so that a 16-bit value can be read or written as a whole over the 8-bit bus. A read of the low byte captures the live high byte into the buffer. A write of the high byte only fills the buffer, and the following low-byte write loads all sixteen bits in one cycle.

Top module: `pscl_timer16`

## Requirements
- R1: After reset the count is 0x0000, the high-byte buffer is 0x00, the overflow flag is 0 and the prescaler count is cleared.
- R2: With `src_ext_i`=0 the counter advances once per cycle in which `tick_i` is 1, and edges on `ext_clk_i` have no effect.
- R3: With `src_ext_i`=1 the counter advances once per rising edge of `ext_clk_i`, and `tick_i` has no effect.
- R4: If `ext_clk_i` is low at clock edge k-1 and high at edge k, the count has advanced after edge k+2 when `sync_en_i`=1 and after edge k+1 when `sync_en_i`=0.
- R5: `pre_sel_i` values 0, 1, 2 and 3 divide the source by 1, 2, 4 and 8: N source events after a counter write advance the count by floor(N / 2^pre_sel_i).
- R6: While `run_en_i`=0 the count and the prescaler count hold their values whatever the source does.
- R7: An advance from 0xFFFF gives 0x0000 and sets `ovf_flag_o`, which stays 1 until cleared.
- R8: A cycle with `ovf_clr_i`=1 clears the flag, unless an overflow happens in the same cycle, in which case the flag stays 1.
- R9: A read (`rd_en_i`=1) at address 0 returns the count's low byte and copies the live high byte into the buffer. A read at address 1 returns the buffer. `rdata_o` is 0x00 when `rd_en_i`=0.
- R10: A write at address 1 loads only the buffer. A write at address 0 loads the count with {buffer, `wdata_i`}, and this write wins over an advance in the same cycle.
- R11: A write at address 0 clears the prescaler count. `pre_sel_i` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Internal instruction-cycle tick strobe |
| ext_clk_i | input | 1 | External count clock pin |
| src_ext_i | input | 1 | Source select: 0 tick strobe, 1 external pin |
| sync_en_i | input | 1 | 1: two-flop synchronizer on the pin, 0: single stage |
| pre_sel_i | input | 2 | Prescale exponent (divide by 2^value) |
| run_en_i | input | 1 | Counting enable |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 low byte, 1 high-byte buffer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ovf_clr_i | input | 1 | Overflow flag clear (software writes 0) |
| ovf_flag_o | output | 1 | Overflow interrupt flag |

## Verification
The bench builds the block with its defaults: a byte-wide bus, a 2-bit prescale field and a two-stage synchronizer. With these values it can reach every divide ratio up to 8 and can measure the difference of exactly one cycle between synchronized and bypassed external edges. Overflow is reached quickly by preloading 0xFFFE through the buffered write path. The same preload sets up the case where an overflow and a flag clear land in one cycle.

// File: rtl/tmr_pkg.sv
// Shared definitions for the prescaled timer: register address codes.
package tmr_pkg;
    typedef enum logic {
        REG_LO = 1'b0,
        REG_HI = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/tmr_edge_src.sv
// External pin edge source. Samples the pin on the system clock and produces
// a one-cycle pulse per rising edge. With sync_en_i set the last of
// SYNC_STAGES flops feeds the detector; otherwise the first flop does.
// Assumes pin edges are slower than half the system clock.
module tmr_edge_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sync_en_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   sel_w;
    logic                   prev_q;

    // Shift the pin through the sampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    // Pick the tap that feeds the edge detector.
    generate
        if (SYNC_STAGES > 1) begin : g_tap
            assign sel_w = sync_en_i ? stage_q[SYNC_STAGES-1] : stage_q[0];
        end else begin : g_single
            assign sel_w = stage_q[0];
        end
    endgenerate

    // Remember the previous tap value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_w;
    end

    assign rise_o = sel_w & ~prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
// Power-of-two prescaler. Emits step_o on every 2^sel_i-th input pulse.
// Compares only the low sel_i bits, so changing sel_i needs no reset.
// clr_i restarts the count without touching sel_i.
module tmr_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clr_i,
    output logic             step_o
);
    localparam int PCNT_W = (1 << SEL_W) - 1;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] mask_w;

    // Build a mask with sel_i low bits set.
    always_comb begin
        for (int b = 0; b < PCNT_W; b++) begin
            mask_w[b] = (b < int'(sel_i));
        end
    end

    assign step_o = pulse_i && ((pcnt_q & mask_w) == mask_w);

    // Advance or restart the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pcnt_q <= '0;
        end else if (pulse_i) begin
            pcnt_q <= step_o ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
// Counter, high-byte holding buffer, byte read mux and overflow flag.
// A low-byte write loads {buffer, data}; a low-byte read refreshes the buffer.
// Assumes at most one of read/write per cycle; a write wins if both occur.
module tmr_count_core #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                rd_en_i,
    input  logic                wr_en_i,
    input  logic                addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                ovf_clr_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [2*DATA_W-1:0] count_o,
    output logic [DATA_W-1:0]   hbuf_o,
    output logic                ovf_flag_o
);
    import tmr_pkg::*;
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hbuf_q;
    logic              flag_q;
    logic              wr_lo, wr_hi, rd_lo, ovf_evt;

    assign wr_lo   = wr_en_i && (addr_i == REG_LO);
    assign wr_hi   = wr_en_i && (addr_i == REG_HI);
    assign rd_lo   = rd_en_i && (addr_i == REG_LO);
    assign ovf_evt = step_i && !wr_lo && (cnt_q == {CNT_W{1'b1}});

    // Load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_lo)  cnt_q <= {hbuf_q, wdata_i};
        else if (step_i) cnt_q <= cnt_q + 1'b1;
    end

    // Fill the high-byte buffer from the bus or from the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)     hbuf_q <= '0;
        else if (wr_hi) hbuf_q <= wdata_i;
        else if (rd_lo) hbuf_q <= cnt_q[CNT_W-1:DATA_W];
    end

    // Overflow flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (ovf_evt)   flag_q <= 1'b1;
        else if (ovf_clr_i) flag_q <= 1'b0;
    end

    // Byte read mux.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            rdata_o = (addr_i == REG_LO) ? cnt_q[DATA_W-1:0] : hbuf_q;
        end
    end

    assign count_o    = cnt_q;
    assign hbuf_o     = hbuf_q;
    assign ovf_flag_o = flag_q;
endmodule

// File: rtl/pscl_timer16.sv
// Prescaled timer/counter top. Selects tick strobe or external edges, gates
// them with run_en_i, divides through the prescaler and counts. A low-byte
// write also restarts the prescaler.
module pscl_timer16 #(
    parameter int DATA_W      = 8,
    parameter int PRE_SEL_W   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 ext_clk_i,
    input  logic                 src_ext_i,
    input  logic                 sync_en_i,
    input  logic [PRE_SEL_W-1:0] pre_sel_i,
    input  logic                 run_en_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic                 addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic                 ovf_clr_i,
    output logic                 ovf_flag_o
);
    import tmr_pkg::*;

    logic                  ext_rise_w;
    logic                  src_pulse_w;
    logic                  step_w;
    logic                  pre_clr_w;
    logic [2*DATA_W-1:0]   count_w;
    logic [DATA_W-1:0]     hbuf_w;

    tmr_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (ext_clk_i),
        .sync_en_i (sync_en_i),
        .rise_o    (ext_rise_w)
    );

    assign src_pulse_w = run_en_i && (src_ext_i ? ext_rise_w : tick_i);
    assign pre_clr_w   = wr_en_i && (addr_i == REG_LO);

    tmr_prescaler #(.SEL_W(PRE_SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (src_pulse_w),
        .sel_i   (pre_sel_i),
        .clr_i   (pre_clr_w),
        .step_o  (step_w)
    );

    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_w),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .ovf_clr_i  (ovf_clr_i),
        .rdata_o    (rdata_o),
        .count_o    (count_w),
        .hbuf_o     (hbuf_w),
        .ovf_flag_o (ovf_flag_o)
    );
endmodule

// File: rtl/pscl_timer16_chk.sv
// Property checker for pscl_timer16, attached by bind below.
module pscl_timer16_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_en_i,
    input logic                rd_en_i,
    input logic                wr_en_i,
    input logic                addr_i,
    input logic [DATA_W-1:0]   wdata_i,
    input logic [DATA_W-1:0]   rdata_o,
    input logic                ovf_clr_i,
    input logic                ovf_flag_o,
    input logic                step_w,
    input logic [2*DATA_W-1:0] count_w,
    input logic [DATA_W-1:0]   hbuf_w
);
    logic wr_lo_c, ovf_c;
    assign wr_lo_c = wr_en_i && !addr_i;
    assign ovf_c   = step_w && !wr_lo_c && (count_w == {2*DATA_W{1'b1}});

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en_i && !wr_en_i) |=> $stable(count_w));

    // R6
    no_step_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |-> !step_w);

    // R5
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w && !wr_lo_c && !ovf_c) |=> (count_w == $past(count_w) + 1'b1));

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_c |=> (ovf_flag_o && count_w == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr_i && !ovf_c) |=> !ovf_flag_o);

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rdata_o == '0));

    // R10
    wr_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_c |=> (count_w == {$past(hbuf_w), $past(wdata_i)}));
endmodule

bind pscl_timer16 pscl_timer16_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en_i   (run_en_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .ovf_clr_i  (ovf_clr_i),
    .ovf_flag_o (ovf_flag_o),
    .step_w     (step_w),
    .count_w    (count_w),
    .hbuf_w     (hbuf_w)
);

// File: tb/pscl_timer16_test.sv
`timescale 1ns/1ps
module pscl_timer16_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, ext_clk_i = 1'b0, src_ext_i = 1'b0, sync_en_i = 1'b1;
    logic [1:0] pre_sel_i = 2'd0;
    logic       run_en_i = 1'b0, rd_en_i = 1'b0, wr_en_i = 1'b0, addr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       ovf_clr_i = 1'b0;
    logic       ovf_flag_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pscl_timer16 uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
        .src_ext_i(src_ext_i), .sync_en_i(sync_en_i), .pre_sel_i(pre_sel_i),
        .run_en_i(run_en_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .ovf_clr_i(ovf_clr_i), .ovf_flag_o(ovf_flag_o)
    );

    // Vector: {is_write, addr, data, expected read}
    localparam logic [17:0] VEC [0:13] = '{
        {1'b1, 1'b1, 8'h12, 8'h00},
        {1'b1, 1'b0, 8'h34, 8'h00},
        {1'b0, 1'b0, 8'h00, 8'h34},
        {1'b0, 1'b1, 8'h00, 8'h12},
        {1'b1, 1'b1, 8'hAB, 8'h00},
        {1'b0, 1'b0, 8'h00, 8'h34},
        {1'b0, 1'b1, 8'h00, 8'h12},
        {1'b1, 1'b0, 8'h56, 8'h00},
        {1'b0, 1'b0, 8'h00, 8'h56},
        {1'b0, 1'b1, 8'h00, 8'h12},
        {1'b1, 1'b1, 8'hFF, 8'h00},
        {1'b1, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] v);
        @(negedge clk); rd_en_i = 1'b1; addr_i = a;
        #1 v = rdata_o;
        @(negedge clk); rd_en_i = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(1'b0, lo);
        bus_rd(1'b1, hi);
        v = {hi, lo};
    endtask

    task automatic wr16(input logic [15:0] v);
        bus_wr(1'b1, v[15:8]);
        bus_wr(1'b0, v[7:0]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk_i = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_i = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd16(v);
        check("R1 count", v, 16'h0000);
        check("R1 flag", {15'd0, ovf_flag_o}, 16'd0);
        @(negedge clk); #1 check("R9 idle rdata", {8'd0, rdata_o}, 16'd0);

        // R9 / R10 table walk, counter stopped
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][17]) bus_wr(VEC[i][16], VEC[i][15:8]);
            else begin
                bus_rd(VEC[i][16], b);
                check($sformatf("R9 R10 vec%0d", i), {8'd0, b}, {8'd0, VEC[i][7:0]});
            end
        end

        // R5 prescale ratios on the tick source (R2)
        run_en_i = 1'b1; src_ext_i = 1'b0;
        for (int s = 0; s < 4; s++) begin
            pre_sel_i = 2'(s);
            wr16(16'h0000);
            ticks(20);
            rd16(v);
            check($sformatf("R5 R2 div sel%0d", s), v, 16'(20 >> s));
        end

        // R2 external edges ignored in tick mode
        pre_sel_i = 2'd0;
        wr16(16'h0040);
        ext_edges(3);
        rd16(v);
        check("R2 ext ignored", v, 16'h0040);

        // R6 enable off holds count and prescaler
        pre_sel_i = 2'd2;
        wr16(16'h0000);
        ticks(3);
        run_en_i = 1'b0;
        ticks(6);
        rd16(v);
        check("R6 hold count", v, 16'h0000);
        run_en_i = 1'b1;
        ticks(1);
        rd16(v);
        check("R6 prescaler held", v, 16'h0001);

        // R11 low-byte write restarts prescaler
        wr16(16'h0000);
        ticks(3);
        wr16(16'h0100);
        ticks(3);
        rd16(v);
        check("R11 restart a", v, 16'h0100);
        ticks(1);
        rd16(v);
        check("R11 restart b", v, 16'h0101);

        // R3 external source, tick ignored
        pre_sel_i = 2'd0; src_ext_i = 1'b1; sync_en_i = 1'b1;
        wr16(16'h0000);
        ext_edges(5);
        ticks(4);
        rd16(v);
        check("R3 ext count", v, 16'h0005);

        // R4 latency, synchronized
        wr16(16'h0000);
        repeat (4) @(negedge clk);
        rd_en_i = 1'b1; addr_i = 1'b0;
        ext_clk_i = 1'b1;
        @(posedge clk); #1 check("R4 sync k", {8'd0, rdata_o}, 16'd0);
        @(posedge clk); #1 check("R4 sync k+1", {8'd0, rdata_o}, 16'd0);
        @(posedge clk); #1 check("R4 sync k+2", {8'd0, rdata_o}, 16'd1);
        @(negedge clk); ext_clk_i = 1'b0; rd_en_i = 1'b0;
        repeat (4) @(negedge clk);

        // R4 latency, bypassed
        sync_en_i = 1'b0;
        wr16(16'h0000);
        repeat (4) @(negedge clk);
        rd_en_i = 1'b1; addr_i = 1'b0;
        ext_clk_i = 1'b1;
        @(posedge clk); #1 check("R4 nosync k", {8'd0, rdata_o}, 16'd0);
        @(posedge clk); #1 check("R4 nosync k+1", {8'd0, rdata_o}, 16'd1);
        @(negedge clk); ext_clk_i = 1'b0; rd_en_i = 1'b0;
        sync_en_i = 1'b1; src_ext_i = 1'b0;
        repeat (4) @(negedge clk);

        // R7 overflow
        wr16(16'hFFFE);
        ticks(1);
        rd16(v);
        check("R7 at FFFF", v, 16'hFFFF);
        check("R7 flag low", {15'd0, ovf_flag_o}, 16'd0);
        ticks(1);
        rd16(v);
        check("R7 wrap", v, 16'h0000);
        check("R7 flag set", {15'd0, ovf_flag_o}, 16'd1);
        ticks(2);
        check("R7 flag stays", {15'd0, ovf_flag_o}, 16'd1);

        // R8 clear, then clear colliding with overflow
        @(negedge clk); ovf_clr_i = 1'b1;
        @(negedge clk); ovf_clr_i = 1'b0;
        check("R8 cleared", {15'd0, ovf_flag_o}, 16'd0);
        wr16(16'hFFFF);
        @(negedge clk); tick_i = 1'b1; ovf_clr_i = 1'b1;
        @(negedge clk); tick_i = 1'b0; ovf_clr_i = 1'b0;
        check("R8 set wins", {15'd0, ovf_flag_o}, 16'd1);

        // R10 write beats advance in same cycle
        @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 1'b0; wdata_i = 8'h77;
        @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
        rd16(v);
        check("R10 write priority", v, 16'hFF77);

        done = 1'b1;
        finish_run();
    end
endmodule